// File: doc/BRIEF.md
# Register-Controlled Shifter with Carry

This block shifts or rotates a data word by an amount held in a register, and returns both the shifted word and the new carry flag. A two-bit select picks one of four operations: logical left, logical right, arithmetic right and rotate right. The carry follows fixed rules when the amount is zero, equal to the word width, or larger than it.

Only the low eight bits of the amount word count, so the amount runs from 0 to 255. Amounts at or beyond the word width are legal inputs and give defined results. A parameter chooses between a purely combinational path and a path with one register stage on both outputs.

Top module: `barrel_shift_carry`

## Requirements
- R1: Only amount_in[7:0] sets the shift amount; bits above bit 7 of amount_in have no effect on either output.
- R2: With an amount of zero, result_out equals data_in and carry_out equals carry_in, for every op_sel value.
- R3: Logical left (op_sel 2'b00) by n in 1..W-1 gives data_in shifted left by n with zero fill, and the carry is data_in[W-n].
- R4: Logical left (op_sel 2'b00) by exactly W gives a zero result with the carry equal to data_in[0]; by more than W, the result and the carry are both zero.
- R5: Logical right (op_sel 2'b01) by n in 1..W-1 gives data_in shifted right by n with zero fill, and the carry is data_in[n-1].
- R6: Logical right (op_sel 2'b01) by exactly W gives a zero result with the carry equal to data_in[W-1]; by more than W, the result and the carry are both zero.
- R7: Arithmetic right (op_sel 2'b10) by n in 1..W-1 gives data_in shifted right by n with sign fill, and the carry is data_in[n-1].
- R8: Arithmetic right (op_sel 2'b10) by W or more fills every result bit with data_in[W-1], and the carry equals data_in[W-1].
- R9: Rotate right (op_sel 2'b11) uses the amount modulo W; when that remainder r is non-zero, the result is data_in rotated right by r and the carry is data_in[r-1].
- R10: Rotate right (op_sel 2'b11) by a non-zero multiple of W leaves the data unchanged and sets the carry to data_in[W-1].
- R11: With REGISTERED=1 both outputs appear one clock after their inputs, and an active-low reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| data_in | input | W | Word to be shifted or rotated |
| amount_in | input | W | Shift amount; only bits [7:0] are used |
| op_sel | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_in | input | 1 | Current carry, kept when the amount is zero |
| result_out | output | W | Shifted or rotated word |
| carry_out | output | 1 | Updated carry |

## Verification
The bench builds two copies at W=32: one with REGISTERED=0, which shows the combinational rules at once, and one with REGISTERED=1, which brings the one-cycle latency, the reset value and the clocked properties on the wide-amount and zero-amount cases within reach. Each vector is applied to both copies, so every amount class (zero, 1 to 31, exactly 32, above 32, and amounts with upper bits set) is checked on both paths.

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry #(
  parameter int W          = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] amount_in,
  input  logic [1:0]   op_sel,
  input  logic         carry_in,
  output logic [W-1:0] result_out,
  output logic         carry_out
);
  localparam int         RW = $clog2(W);
  localparam logic [7:0] WB = 8'(W);

  logic [7:0]    amt;
  logic [RW-1:0] rot;
  logic          unused_amt_hi;
  assign amt           = amount_in[7:0];
  assign rot           = amt[RW-1:0];
  assign unused_amt_hi = ^amount_in[W-1:8];

  // The spare bit beside the word catches the last bit shifted out.
  logic [W:0]        lsl_ext, lsr_ext;
  logic signed [W:0] asr_ext;
  logic [2*W-1:0]    ror_ext;
  assign lsl_ext = {1'b0, data_in} << amt;
  assign lsr_ext = {data_in, 1'b0} >> amt;
  assign asr_ext = $signed({data_in, 1'b0}) >>> amt;
  assign ror_ext = {data_in, data_in} >> rot;

  logic [W-1:0] res_c;
  logic         car_c;
  always_comb begin
    res_c = data_in;
    car_c = carry_in;
    if (amt != 8'd0) begin
      unique case (op_sel)
        2'b00: begin res_c = lsl_ext[W-1:0]; car_c = lsl_ext[W]; end
        2'b01: begin res_c = lsr_ext[W:1];   car_c = lsr_ext[0]; end
        2'b10: begin res_c = asr_ext[W:1];   car_c = asr_ext[0]; end
        default: begin res_c = ror_ext[W-1:0]; car_c = ror_ext[W-1]; end
      endcase
    end
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result_out <= '0;
          carry_out  <= 1'b0;
        end else begin
          result_out <= res_c;
          carry_out  <= car_c;
        end
      end

      p_zero_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (amount_in[7:0] == 8'd0) |=>
          (result_out == $past(data_in)) && (carry_out == $past(carry_in)));

      p_lsl_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b00 && amount_in[7:0] > WB) |=>
          (result_out == '0) && !carry_out);

      p_lsr_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b01 && amount_in[7:0] > WB) |=>
          (result_out == '0) && !carry_out);

      p_asr_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b10 && amount_in[7:0] >= WB) |=>
          (result_out == {W{$past(data_in[W-1])}}) &&
          (carry_out == $past(data_in[W-1])));

      p_ror_whole_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b11 && amount_in[7:0] != 8'd0 && amount_in[RW-1:0] == '0) |=>
          (result_out == $past(data_in)) && (carry_out == $past(data_in[W-1])));
    end else begin : g_comb
      assign result_out = res_c;
      assign carry_out  = car_c;
    end
  endgenerate
endmodule

// File: tb/sim_barrel_shift_carry.sv
`timescale 1ns/100ps
module sim_barrel_shift_carry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data_in = '0, amount_in = '0;
  logic [1:0]  op_sel = '0;
  logic        carry_in = 1'b0;
  logic [31:0] res0, res1;
  logic        car0, car1;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  barrel_shift_carry #(.W(32), .REGISTERED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .amount_in(amount_in),
    .op_sel(op_sel), .carry_in(carry_in), .result_out(res0), .carry_out(car0));
  barrel_shift_carry #(.W(32), .REGISTERED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .amount_in(amount_in),
    .op_sel(op_sel), .carry_in(carry_in), .result_out(res1), .carry_out(car1));

  // {req, op, amount, data, carry_in, expected result, expected carry}
  localparam int NV = 22;
  localparam logic [107:0] VEC [NV] = '{
    {8'd3,  2'b00, 32'd4,          32'hF000_000F, 1'b0, 32'h0000_00F0, 1'b1}, // R3
    {8'd3,  2'b00, 32'd1,          32'h4000_0000, 1'b1, 32'h8000_0000, 1'b0}, // R3
    {8'd3,  2'b00, 32'd31,         32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0}, // R3
    {8'd4,  2'b00, 32'd32,         32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1}, // R4
    {8'd4,  2'b00, 32'd33,         32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R4
    {8'd5,  2'b01, 32'd8,          32'h1234_5680, 1'b0, 32'h0012_3456, 1'b1}, // R5
    {8'd5,  2'b01, 32'd1,          32'h0000_0002, 1'b1, 32'h0000_0001, 1'b0}, // R5
    {8'd6,  2'b01, 32'd32,         32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R6
    {8'd6,  2'b01, 32'd200,        32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R6
    {8'd7,  2'b10, 32'd4,          32'h8000_0018, 1'b0, 32'hF800_0001, 1'b1}, // R7
    {8'd7,  2'b10, 32'd31,         32'h4000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R7
    {8'd8,  2'b10, 32'd40,         32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R8
    {8'd8,  2'b10, 32'd32,         32'h7FFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R8
    {8'd9,  2'b11, 32'd4,          32'h1234_5678, 1'b0, 32'h8123_4567, 1'b1}, // R9
    {8'd9,  2'b11, 32'd36,         32'h1234_5678, 1'b0, 32'h8123_4567, 1'b1}, // R9
    {8'd10, 2'b11, 32'd64,         32'h8000_0001, 1'b0, 32'h8000_0001, 1'b1}, // R10
    {8'd10, 2'b11, 32'd32,         32'h7000_0000, 1'b1, 32'h7000_0000, 1'b0}, // R10
    {8'd2,  2'b00, 32'd0,          32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, 1'b1}, // R2
    {8'd2,  2'b11, 32'd0,          32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0}, // R2
    {8'd2,  2'b10, 32'd0,          32'h8000_0001, 1'b0, 32'h8000_0001, 1'b0}, // R2
    {8'd1,  2'b01, 32'h0000_0104,  32'h0000_00F0, 1'b1, 32'h0000_000F, 1'b0}, // R1
    {8'd1,  2'b10, 32'hFFFF_FF00,  32'h8000_0000, 1'b1, 32'h8000_0000, 1'b1}  // R1
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] got_r, input logic [31:0] exp_r,
                       input logic got_c, input logic exp_c);
    n_chk++;
    if (got_r !== exp_r || got_c !== exp_c) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h/%b expected %h/%b", req, what, got_r, got_c, exp_r, exp_c);
    end
  endtask

  task automatic apply(input logic [107:0] v);
    op_sel    = v[99:98];
    amount_in = v[97:66];
    data_in   = v[65:34];
    carry_in  = v[33];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check(11, "reset state", res1, 32'h0, car1, 1'b0); // R11
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      #1;
      check(int'(VEC[i][107:100]), "comb path", res0, VEC[i][32:1], car0, VEC[i][0]);
      @(negedge clk);
      check(int'(VEC[i][107:100]), "registered path", res1, VEC[i][32:1], car1, VEC[i][0]);
    end
    // R11: the registered copy holds the previous value until the next edge
    apply(VEC[0]);
    @(negedge clk);
    apply(VEC[5]);
    #1;
    check(11, "latency hold", res1, VEC[0][32:1], car1, VEC[0][0]);
    @(negedge clk);
    check(11, "latency update", res1, VEC[5][32:1], car1, VEC[5][0]);
    // R11: reset clears a non-zero registered output
    rst_n = 1'b0;
    #1;
    check(11, "reset clear", res1, 32'h0, car1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule